// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit decides where a 32-bit core with fixed 4-byte instructions fetches next. For each request it receives the current program counter, the instruction word, the two register values the instruction names (compare sources for a conditional branch, or the target for a register jump), and the return-address register value. From these it produces the next program counter. For calls it also produces a write of the return address into register 31. When a register-sourced target is not word aligned, it raises a fault and captures the target address.

The unit handles the following flow-control forms:
- absolute jumps and calls that carry a 26-bit word index;
- PC-relative branches, both unconditional and conditioned on a signed or unsigned compare;
- register jumps, register calls and returns.

Every other opcode falls through to the sequential address. Results are registered. They appear one cycle after a request is presented with `req_valid`. The output PC comes out of reset at a parameterised vector.

Top module: `npc_resolve`

## Requirements
- R1: While reset is asserted and after it is released with no request, `out_valid`, `link_we` and `exc_misalign` are 0 and `next_pc` equals the parameter `RESET_VEC`.
- R2: Opcode 0x01 (instruction bits [5:0]) sets `next_pc` to the upper four bits of the current PC, followed by instruction bits [31:6], followed by two zero bits. `link_we` stays 0.
- R3: Opcode 0x00 gives the same target as R2, and also sets `link_we` to 1 with `link_data` equal to the current PC plus 4.
- R4: Opcode 0x06 sets `next_pc` to PC+4 plus the sign-extended 16-bit field at bits [21:6], with the field's two low bits cleared first.
- R5: Opcodes 0x0E, 0x16, 0x1E and 0x26 are signed compares of `opnd_a` against `opnd_b`: greater-or-equal, less-than, not-equal and equal. When the compare holds, the target is the one from R4. Otherwise `next_pc` is PC+4.
- R6: Opcodes 0x2E and 0x36 work as in R5, but with unsigned greater-or-equal and unsigned less-than.
- R7: Opcode 0x3A selects a register form through bits [16:11]. Value 0x0D jumps to `opnd_a`. Value 0x1D jumps to `opnd_a` and writes PC+4 as the link. Value 0x05 jumps to `ret_addr`. Only 0x1D writes the link.
- R8: If the register-form target has a nonzero bit [1:0], the unit does not jump. It sets `exc_misalign` to 1 with `exc_addr` equal to that target, sets `next_pc` to PC+4, and keeps `link_we` at 0.
- R9: Any other opcode, or any other bits [16:11] value under opcode 0x3A, gives `next_pc` = PC+4 with no link write and no fault.
- R10: Outputs update on the clock edge that samples `req_valid` high. A cycle with `req_valid` low gives `out_valid`, `link_we` and `exc_misalign` of 0 and leaves `next_pc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| cur_pc | input | 32 | Address of the instruction being resolved |
| insn | input | 32 | Instruction word |
| opnd_a | input | 32 | First register operand (compare source or jump target) |
| opnd_b | input | 32 | Second register operand (compare source) |
| ret_addr | input | 32 | Value of the return-address register (index 31) |
| out_valid | output | 1 | Registered results belong to a request |
| next_pc | output | 32 | Resolved next program counter |
| link_we | output | 1 | Write `link_data` to register 31 |
| link_data | output | 32 | Return address for calls |
| exc_misalign | output | 1 | Misaligned register-target fault |
| exc_addr | output | 32 | Faulting target address |

## Verification
The bench targets several corner cases, each paired with the wrong behaviour it would catch:
- Sign handling of the compares: -1 against 1 is run under both signed and unsigned branches. A unit that mixes the two takes the wrong path.
- Operand equality, which must take greater-or-equal and equal but not not-equal.
- A negative branch offset with set low bits. Failing to clear those bits, or to sign-extend the field, lands on a misaligned or far address.
- An absolute call whose field is all ones. This shows whether the top PC bits are kept.
- Misaligned register targets on a jump, a call and a return. A faulty unit would jump anyway, or would write the link despite the fault.
- A return with a misaligned `opnd_a`. This proves the return reads its own register.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN    = 32;
  localparam int OPW     = 6;
  localparam int IMM16W  = 16;
  localparam int IMM26W  = 26;
  localparam int SEGW    = XLEN - IMM26W - 2;
  localparam int INSN_B  = 4;

  localparam logic [OPW-1:0] OP_CALL  = 6'h00;
  localparam logic [OPW-1:0] OP_JABS  = 6'h01;
  localparam logic [OPW-1:0] OP_BR    = 6'h06;
  localparam logic [OPW-1:0] OP_BGE   = 6'h0E;
  localparam logic [OPW-1:0] OP_BLT   = 6'h16;
  localparam logic [OPW-1:0] OP_BNE   = 6'h1E;
  localparam logic [OPW-1:0] OP_BEQ   = 6'h26;
  localparam logic [OPW-1:0] OP_BGEU  = 6'h2E;
  localparam logic [OPW-1:0] OP_BLTU  = 6'h36;
  localparam logic [OPW-1:0] OP_REGF  = 6'h3A;
  localparam logic [OPW-1:0] XOP_RET  = 6'h05;
  localparam logic [OPW-1:0] XOP_JR   = 6'h0D;
  localparam logic [OPW-1:0] XOP_CLR  = 6'h1D;

  typedef enum logic [2:0] {
    FL_SEQ, FL_JABS, FL_CALL, FL_BR, FL_BCOND, FL_JREG, FL_CALLR, FL_RET
  } flow_e;

  typedef enum logic [2:0] {
    CMP_GE, CMP_LT, CMP_NE, CMP_EQ, CMP_GEU, CMP_LTU
  } cmp_e;

  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(INSN_B);
  endfunction

  function automatic logic [XLEN-1:0] abs_target(input logic [XLEN-1:0] pc,
                                                 input logic [IMM26W-1:0] idx);
    return {pc[XLEN-1 -: SEGW], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] pc,
                                                 input logic [IMM16W-1:0] off);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-IMM16W){off[IMM16W-1]}}, off[IMM16W-1:2], 2'b00};
    return seq_pc(pc) + ext;
  endfunction

  function automatic logic cmp_holds(input cmp_e k, input logic [XLEN-1:0] a,
                                     input logic [XLEN-1:0] b);
    case (k)
      CMP_GE:  return $signed(a) >= $signed(b);
      CMP_LT:  return $signed(a) <  $signed(b);
      CMP_NE:  return a != b;
      CMP_EQ:  return a == b;
      CMP_GEU: return a >= b;
      CMP_LTU: return a <  b;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] insn,
  output flow_e           flow,
  output cmp_e            cmp
);
  logic [OPW-1:0] op;
  logic [OPW-1:0] xop;

  assign op  = insn[OPW-1:0];
  assign xop = insn[16:11];

  always_comb begin
    flow = FL_SEQ;
    cmp  = CMP_EQ;
    case (op)
      OP_CALL: flow = FL_CALL;
      OP_JABS: flow = FL_JABS;
      OP_BR:   flow = FL_BR;
      OP_BGE:  begin flow = FL_BCOND; cmp = CMP_GE;  end
      OP_BLT:  begin flow = FL_BCOND; cmp = CMP_LT;  end
      OP_BNE:  begin flow = FL_BCOND; cmp = CMP_NE;  end
      OP_BEQ:  begin flow = FL_BCOND; cmp = CMP_EQ;  end
      OP_BGEU: begin flow = FL_BCOND; cmp = CMP_GEU; end
      OP_BLTU: begin flow = FL_BCOND; cmp = CMP_LTU; end
      OP_REGF: begin
        case (xop)
          XOP_JR:  flow = FL_JREG;
          XOP_CLR: flow = FL_CALLR;
          XOP_RET: flow = FL_RET;
          default: flow = FL_SEQ;
        endcase
      end
      default: flow = FL_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] insn,
  input  flow_e           flow,
  input  cmp_e            cmp,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] ret_reg,
  output logic [XLEN-1:0] npc,
  output logic            lwe,
  output logic [XLEN-1:0] lval,
  output logic            fault,
  output logic [XLEN-1:0] fault_addr,
  output logic            taken
);
  logic [XLEN-1:0] ind_tgt;
  logic            is_ind;
  logic            ind_bad;

  assign ind_tgt = (flow == FL_RET) ? ret_reg : opa;
  assign is_ind  = (flow == FL_JREG) || (flow == FL_CALLR) || (flow == FL_RET);
  assign ind_bad = is_ind && (ind_tgt[1:0] != 2'b00);
  assign taken   = cmp_holds(cmp, opa, opb);

  always_comb begin
    case (flow)
      FL_JABS, FL_CALL:          npc = abs_target(pc, insn[XLEN-1:OPW]);
      FL_BR:                     npc = rel_target(pc, insn[21:6]);
      FL_BCOND:                  npc = taken ? rel_target(pc, insn[21:6]) : seq_pc(pc);
      FL_JREG, FL_CALLR, FL_RET: npc = ind_bad ? seq_pc(pc) : ind_tgt;
      default:                   npc = seq_pc(pc);
    endcase
  end

  assign lwe        = (flow == FL_CALL) || ((flow == FL_CALLR) && !ind_bad);
  assign lval       = seq_pc(pc);
  assign fault      = ind_bad;
  assign fault_addr = ind_bad ? ind_tgt : '0;
endmodule

// File: rtl/npc_resolve.sv
module npc_resolve
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0001_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] insn,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] ret_addr,
  output logic            out_valid,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            exc_misalign,
  output logic [XLEN-1:0] exc_addr
);
  flow_e           flow;
  cmp_e            cmp;
  logic [XLEN-1:0] c_npc;
  logic            c_lwe;
  logic [XLEN-1:0] c_lval;
  logic            c_fault;
  logic [XLEN-1:0] c_faddr;
  logic            c_taken;

  npc_decode u_dec (
    .insn (insn),
    .flow (flow),
    .cmp  (cmp)
  );

  npc_target u_tgt (
    .pc         (cur_pc),
    .insn       (insn),
    .flow       (flow),
    .cmp        (cmp),
    .opa        (opnd_a),
    .opb        (opnd_b),
    .ret_reg    (ret_addr),
    .npc        (c_npc),
    .lwe        (c_lwe),
    .lval       (c_lval),
    .fault      (c_fault),
    .fault_addr (c_faddr),
    .taken      (c_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      next_pc      <= RESET_VEC;
      link_we      <= 1'b0;
      link_data    <= '0;
      exc_misalign <= 1'b0;
      exc_addr     <= '0;
    end else begin
      out_valid    <= req_valid;
      link_we      <= req_valid & c_lwe;
      exc_misalign <= req_valid & c_fault;
      if (req_valid) begin
        next_pc   <= c_npc;
        link_data <= c_lval;
        exc_addr  <= c_faddr;
      end
    end
  end

  // R3
  link_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> out_valid);

  // R3
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_data == $past(cur_pc) + 32'd4);

  // R8
  no_link_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_misalign |-> !link_we);

  // R8
  fault_addr_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_misalign |-> exc_addr[1:0] != 2'b00);

  // R8
  fault_pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_misalign |-> next_pc == $past(cur_pc) + 32'd4);

  // R5
  cond_fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && flow == FL_BCOND && !c_taken) |=> next_pc == $past(cur_pc) + 32'd4);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !link_we && !exc_misalign && $stable(next_pc)));
endmodule

// File: tb/npc_resolve_bench.sv
module npc_resolve_bench;
  localparam logic [31:0] RV = 32'h0001_0000;

  typedef struct packed {
    logic [3:0]  rq;
    logic [31:0] pc;
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic [31:0] npc;
    logic        lwe;
    logic [31:0] link;
    logic        exc;
    logic [31:0] bad;
  } vec_t;

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [15:0] imm);
    return {10'h0, imm, op};
  endfunction
  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] idx);
    return {idx, op};
  endfunction
  function automatic logic [31:0] mk_r(input logic [5:0] x);
    return {15'h0, x, 5'h0, 6'h3A};
  endfunction

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R2 absolute jump keeps top PC bits
    '{4'd2, 32'h3000_0100, mk_j(6'h01, 26'h0123456), 32'h0, 32'h0, 32'h0, 32'h3048_D158, 1'b0, 32'h0, 1'b0, 32'h0},
    // R3 absolute call, all-ones index
    '{4'd3, 32'hA000_0010, mk_j(6'h00, 26'h3FF_FFFF), 32'h0, 32'h0, 32'h0, 32'hAFFF_FFFC, 1'b1, 32'hA000_0014, 1'b0, 32'h0},
    // R4 forward branch, low bits cleared
    '{4'd4, 32'h0000_1000, mk_i(6'h06, 16'h0013), 32'h0, 32'h0, 32'h0, 32'h0000_1014, 1'b0, 32'h0, 1'b0, 32'h0},
    // R4 backward branch
    '{4'd4, 32'h0000_1000, mk_i(6'h06, 16'hFFF7), 32'h0, 32'h0, 32'h0, 32'h0000_0FF8, 1'b0, 32'h0, 1'b0, 32'h0},
    // R5 signed ge: -1 >= -5
    '{4'd5, 32'h0000_0200, mk_i(6'h0E, 16'h0040), 32'hFFFF_FFFF, 32'hFFFF_FFFB, 32'h0, 32'h0000_0244, 1'b0, 32'h0, 1'b0, 32'h0},
    // R5 signed lt: -1 < 1
    '{4'd5, 32'h0000_0200, mk_i(6'h16, 16'h0040), 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0000_0244, 1'b0, 32'h0, 1'b0, 32'h0},
    // R6 unsigned lt: 0xFFFFFFFF < 1 false
    '{4'd6, 32'h0000_0200, mk_i(6'h36, 16'h0040), 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0000_0204, 1'b0, 32'h0, 1'b0, 32'h0},
    // R6 unsigned ge true
    '{4'd6, 32'h0000_0200, mk_i(6'h2E, 16'h0040), 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0000_0244, 1'b0, 32'h0, 1'b0, 32'h0},
    // R5 ne with equal operands
    '{4'd5, 32'h0000_0200, mk_i(6'h1E, 16'h0040), 32'h7, 32'h7, 32'h0, 32'h0000_0204, 1'b0, 32'h0, 1'b0, 32'h0},
    // R5 eq with equal operands
    '{4'd5, 32'h0000_0200, mk_i(6'h26, 16'h0040), 32'h7, 32'h7, 32'h0, 32'h0000_0244, 1'b0, 32'h0, 1'b0, 32'h0},
    // R5 ge with equal operands
    '{4'd5, 32'h0000_0200, mk_i(6'h0E, 16'h0040), 32'h7, 32'h7, 32'h0, 32'h0000_0244, 1'b0, 32'h0, 1'b0, 32'h0},
    // R7 register jump, no link
    '{4'd7, 32'h0000_0400, mk_r(6'h0D), 32'h0000_8000, 32'h0, 32'h0000_2220, 32'h0000_8000, 1'b0, 32'h0, 1'b0, 32'h0},
    // R7 register call writes link
    '{4'd7, 32'h0000_0400, mk_r(6'h1D), 32'h0000_C000, 32'h0, 32'h0, 32'h0000_C000, 1'b1, 32'h0000_0404, 1'b0, 32'h0},
    // R7 return reads ret_addr, ignores misaligned opnd_a
    '{4'd7, 32'h0000_0400, mk_r(6'h05), 32'h1111_1113, 32'h0, 32'h0000_2220, 32'h0000_2220, 1'b0, 32'h0, 1'b0, 32'h0},
    // R8 misaligned register call
    '{4'd8, 32'h0000_0400, mk_r(6'h1D), 32'h0000_C002, 32'h0, 32'h0, 32'h0000_0404, 1'b0, 32'h0, 1'b1, 32'h0000_C002},
    // R8 misaligned return
    '{4'd8, 32'h0000_0400, mk_r(6'h05), 32'h0, 32'h0, 32'h0000_2223, 32'h0000_0404, 1'b0, 32'h0, 1'b1, 32'h0000_2223},
    // R8 misaligned register jump
    '{4'd8, 32'h0000_0400, mk_r(6'h0D), 32'h0000_8001, 32'h0, 32'h0, 32'h0000_0404, 1'b0, 32'h0, 1'b1, 32'h0000_8001},
    // R9 non-flow opcode
    '{4'd9, 32'h0000_0400, mk_i(6'h04, 16'h1234), 32'h0000_8000, 32'h0, 32'h0, 32'h0000_0404, 1'b0, 32'h0, 1'b0, 32'h0},
    // R9 non-flow register-form selector
    '{4'd9, 32'h0000_0400, mk_r(6'h31), 32'h0000_8000, 32'h0, 32'h0000_2220, 32'h0000_0404, 1'b0, 32'h0, 1'b0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] cur_pc = '0, insn = '0, opnd_a = '0, opnd_b = '0, ret_addr = '0;
  logic        out_valid, link_we, exc_misalign;
  logic [31:0] next_pc, link_data, exc_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  npc_resolve #(.RESET_VEC(RV)) u_npc_resolve (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_pc(cur_pc),
    .insn(insn), .opnd_a(opnd_a), .opnd_b(opnd_b), .ret_addr(ret_addr),
    .out_valid(out_valid), .next_pc(next_pc), .link_we(link_we),
    .link_data(link_data), .exc_misalign(exc_misalign), .exc_addr(exc_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 next_pc in reset", next_pc, RV);
    chk("R1 out_valid in reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1 after release, no request
    chk("R1 next_pc idle", next_pc, RV);
    chk("R1 link_we idle", {31'h0, link_we}, 32'h0);
    chk("R1 exc idle", {31'h0, exc_misalign}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      cur_pc    = VECS[i].pc;
      insn      = VECS[i].ins;
      opnd_a    = VECS[i].a;
      opnd_b    = VECS[i].b;
      ret_addr  = VECS[i].r;
      @(negedge clk);
      chk($sformatf("R%0d vec %0d next_pc", VECS[i].rq, i), next_pc, VECS[i].npc);
      chk($sformatf("R%0d vec %0d link_we", VECS[i].rq, i), {31'h0, link_we}, {31'h0, VECS[i].lwe});
      chk($sformatf("R%0d vec %0d exc", VECS[i].rq, i), {31'h0, exc_misalign}, {31'h0, VECS[i].exc});
      // R10 result valid one cycle after the request
      chk($sformatf("R10 vec %0d out_valid", i), {31'h0, out_valid}, 32'h1);
      if (VECS[i].lwe)
        chk($sformatf("R%0d vec %0d link_data", VECS[i].rq, i), link_data, VECS[i].link);
      if (VECS[i].exc)
        chk($sformatf("R%0d vec %0d exc_addr", VECS[i].rq, i), exc_addr, VECS[i].bad);
    end

    // R10 idle cycle with a call on the inputs: nothing fires, PC holds
    @(negedge clk);
    req_valid = 1'b0;
    cur_pc    = 32'h0000_0800;
    insn      = mk_r(6'h1D);
    opnd_a    = 32'h0000_9002;
    @(negedge clk);
    chk("R10 idle out_valid", {31'h0, out_valid}, 32'h0);
    chk("R10 idle link_we", {31'h0, link_we}, 32'h0);
    chk("R10 idle exc", {31'h0, exc_misalign}, 32'h0);
    chk("R10 idle next_pc held", next_pc, 32'h0000_0404);

    // R1 reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run next_pc", next_pc, RV);
    chk("R1 mid-run out_valid", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule